// File: doc/BRIEF.md
# Vector Operand-Use and Legality Decoder

This block sits in the issue path of a vector unit. It looks at each 32-bit vector arithmetic instruction word and works out which vector register operands the instruction really reads or writes. The result is a set of "uses" flags for a first source, a second source, the destination and the mask register, which a downstream hazard checker consumes. It also flags the one illegal form it polices: a masked merge whose destination is the mask register itself. For that form it reports exception cause 2.

The flags matter most where the instruction fields do not mean what they appear to mean. Some unary groups in the mask/integer-vector encoding reuse the first-source register field as a sub-opcode. If that field were treated as a register number, the hazard checker would stall on a false dependency. The merge and move forms share one function code. Only the masked form reads the mask, and only the masked form is barred from writing the mask register. Results are registered, so they appear one clock after the word is presented.

Top module: `vdec_top`

## Requirements
- R1: While `rstN` is low, every output is 0.
- R2: The outputs for a word presented with `instrValid`=1 appear on the next clock, with `outValid`=1. After a cycle with `instrValid`=0, every output is 0 on the next clock.
- R3: A word is a vector arithmetic word only when bits [6:0] are 1010111 and funct3 (bits [14:12]) is not 111. For any other word, `isVec`, all use flags, `illegal` and `excCause` are 0, while `outValid` is still 1.
- R4: `useVs1` can be 1 only for funct3 000, 001 and 010 (vector-vector encodings). It is always 0 for 011 (immediate), 100 (integer scalar), 101 (float scalar) and 110 (mask/integer scalar).
- R5: funct3 010 with funct6 (bits [31:26]) 010000 is a scalar-result unary group. It gives `useVs1`=0, `useVd`=0 and `useVs2`=1.
- R6: funct3 010 with funct6 010100 is a mask set-first group. It gives `useVs1`=0, `useVd`=1 and `useVs2`=1.
- R7: For any legal vector word, `useMask` is the inverse of vm (bit 25).
- R8: funct6 010111 with vm=0 and vd (bits [11:7]) = 0, in funct3 000, 011, 100 or 101, gives `illegal`=1, `excCause`=2, `isVec`=1 and all use flags 0.
- R9: funct6 010111 with vm=1 in those four encodings is a move form. It is legal even with vd=0, and gives `useVs2`=0 and `useMask`=0.
- R10: funct6 010111 with vm=0 and vd not 0 in those four encodings is a legal merge, with `useVs2`=1 and `useMask`=1. funct6 010111 in funct3 001, 010 or 110 is never flagged illegal.
- R11: `excCause` is 0 whenever `illegal` is 0.
- R12: Any other legal vector word gives `useVs2`=1 and `useVd`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrValid | input | 1 | `instr` carries a word to decode this cycle |
| instr | input | 32 | Instruction word |
| outValid | output | 1 | Registered results below belong to a presented word |
| isVec | output | 1 | Word is a vector arithmetic instruction |
| useVs1 | output | 1 | First vector source is read |
| useVs2 | output | 1 | Second vector source is read |
| useVd | output | 1 | Vector destination is written |
| useMask | output | 1 | Mask register v0 is read |
| illegal | output | 1 | Word is an illegal masked merge onto v0 |
| excCause | output | CauseW | 2 when `illegal`, otherwise 0 |

## Verification
Every result is due exactly one clock after the word is sampled. The bench models this with a queue. At each rising edge it computes the expected outputs from the word then on the inputs, and it compares the front of the queue with the outputs at the following falling edge. Inputs change a short delay after the rising edge, so each sample sees the word that belongs to it. Reset cycles push an all-zero entry, which makes the reset state part of the same one-cycle accounting.

// File: rtl/vdec_pkg.sv
package vdec_pkg;

  localparam int InstrW   = 32;
  localparam int OpcW     = 7;
  localparam int F3W      = 3;
  localparam int F6W      = 6;
  localparam int RegW     = 5;

  localparam int OpcLo    = 0;
  localparam int VdLo     = 7;
  localparam int F3Lo     = 12;
  localparam int VmBit    = 25;
  localparam int F6Lo     = 26;

  localparam logic [OpcW-1:0] VecOpcode  = 7'b1010111;
  localparam logic [F6W-1:0]  F6WxUnary  = 6'b010000;
  localparam logic [F6W-1:0]  F6MskFirst = 6'b010100;
  localparam logic [F6W-1:0]  F6Merge    = 6'b010111;

  typedef enum logic [F3W-1:0] {
    CAT_IVV = 3'b000,
    CAT_FVV = 3'b001,
    CAT_MVV = 3'b010,
    CAT_IVI = 3'b011,
    CAT_IVX = 3'b100,
    CAT_FVF = 3'b101,
    CAT_MVX = 3'b110,
    CAT_CFG = 3'b111
  } catE;

  // strobes from control to datapath
  typedef struct packed {
    logic vecOp;     // vector arithmetic word
    logic vs1Form;   // vector-vector encoding
    logic wxUnary;   // scalar-result unary group, rs1 is sub-opcode
    logic mskFirst;  // set-first group, rs1 is sub-opcode
    logic mergeGrp;  // merge/move function code
    logic mergeEnc;  // encoding where merge/move lives
  } decStrobeT;

  typedef struct packed {
    logic useVs1;
    logic useVs2;
    logic useVd;
    logic useMask;
  } useT;

endpackage

// File: rtl/vdec_ctrl.sv
module vdec_ctrl
  import vdec_pkg::*;
(
  input  logic [OpcW-1:0] opcode,
  input  logic [F3W-1:0]  funct3,
  input  logic [F6W-1:0]  funct6,
  output decStrobeT       strb
);

  catE cat;
  logic isOpv;

  assign cat   = catE'(funct3);
  assign isOpv = (opcode == VecOpcode) && (cat != CAT_CFG);

  always_comb begin
    strb          = '0;
    strb.vecOp    = isOpv;
    unique case (cat)
      CAT_IVV, CAT_FVV, CAT_MVV: strb.vs1Form = isOpv;
      default:                   strb.vs1Form = 1'b0;
    endcase
    strb.wxUnary  = isOpv && (cat == CAT_MVV) && (funct6 == F6WxUnary);
    strb.mskFirst = isOpv && (cat == CAT_MVV) && (funct6 == F6MskFirst);
    strb.mergeGrp = isOpv && (funct6 == F6Merge);
    unique case (cat)
      CAT_IVV, CAT_IVI, CAT_IVX, CAT_FVF: strb.mergeEnc = 1'b1;
      default:                            strb.mergeEnc = 1'b0;
    endcase
  end

endmodule

// File: rtl/vdec_datapath.sv
module vdec_datapath
  import vdec_pkg::*;
#(
  parameter bit          RegOut       = 1'b1,
  parameter int unsigned CauseW       = 5,
  parameter int unsigned IllegalCause = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  decStrobeT         strb,
  input  logic              vm,
  input  logic [RegW-1:0]   vd,
  output logic              outValid,
  output logic              isVec,
  output useT               uses,
  output logic              illegal,
  output logic [CauseW-1:0] excCause
);

  localparam logic [CauseW-1:0] CauseIll = CauseW'(IllegalCause);

  logic              vdZero, moveForm, illC, live, vecC;
  useT               usesC;
  logic [CauseW-1:0] causeC;

  assign vdZero   = (vd == '0);
  assign moveForm = strb.mergeGrp && strb.mergeEnc && vm;
  assign illC     = instrValid && strb.mergeGrp && strb.mergeEnc && !vm && vdZero;
  assign vecC     = instrValid && strb.vecOp;
  assign live     = vecC && !illC;

  always_comb begin
    usesC.useVs1  = live && strb.vs1Form && !strb.wxUnary && !strb.mskFirst;
    usesC.useVs2  = live && !moveForm;
    usesC.useVd   = live && !strb.wxUnary;
    usesC.useMask = live && !vm;
    causeC        = illC ? CauseIll : '0;
  end

  generate
    if (RegOut) begin : gRegOut
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          outValid <= 1'b0;
          isVec    <= 1'b0;
          uses     <= '0;
          illegal  <= 1'b0;
          excCause <= '0;
        end else begin
          outValid <= instrValid;
          isVec    <= vecC;
          uses     <= usesC;
          illegal  <= illC;
          excCause <= causeC;
        end
      end
    end else begin : gCombOut
      assign outValid = instrValid;
      assign isVec    = vecC;
      assign uses     = usesC;
      assign illegal  = illC;
      assign excCause = causeC;
    end
  endgenerate

endmodule

// File: rtl/vdec_top.sv
module vdec_top
  import vdec_pkg::*;
#(
  parameter bit          RegOut       = 1'b1,
  parameter int unsigned CauseW       = 5,
  parameter int unsigned IllegalCause = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [31:0]       instr,
  output logic              outValid,
  output logic              isVec,
  output logic              useVs1,
  output logic              useVs2,
  output logic              useVd,
  output logic              useMask,
  output logic              illegal,
  output logic [CauseW-1:0] excCause
);

  decStrobeT strb;
  useT       uses;
  logic      unusedRegFields;

  assign unusedRegFields = ^instr[24:15];

  vdec_ctrl uCtrl (
    .opcode (instr[OpcLo +: OpcW]),
    .funct3 (instr[F3Lo +: F3W]),
    .funct6 (instr[F6Lo +: F6W]),
    .strb   (strb)
  );

  vdec_datapath #(
    .RegOut       (RegOut),
    .CauseW       (CauseW),
    .IllegalCause (IllegalCause)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .instrValid (instrValid),
    .strb       (strb),
    .vm         (instr[VmBit]),
    .vd         (instr[VdLo +: RegW]),
    .outValid   (outValid),
    .isVec      (isVec),
    .uses       (uses),
    .illegal    (illegal),
    .excCause   (excCause)
  );

  assign useVs1  = uses.useVs1;
  assign useVs2  = uses.useVs2;
  assign useVd   = uses.useVd;
  assign useMask = uses.useMask;

endmodule

// File: rtl/vdec_chk.sv
module vdec_chk #(
  parameter int unsigned CauseW = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              instrValid,
  input logic [31:0]       instr,
  input logic              outValid,
  input logic              isVec,
  input logic              useVs1,
  input logic              useVs2,
  input logic              useVd,
  input logic              useMask,
  input logic              illegal,
  input logic [CauseW-1:0] excCause
);

  logic       opv, f3Scalar, f3MergeEnc, mergeF6;
  logic [2:0] f3;
  logic       unusedChkBits;

  assign unusedChkBits = ^instr[24:15];
  assign f3         = instr[14:12];
  assign opv        = (instr[6:0] == 7'b1010111) && (f3 != 3'b111);
  assign f3Scalar   = (f3 == 3'b011) || (f3 == 3'b100) || (f3 == 3'b101) || (f3 == 3'b110);
  assign f3MergeEnc = (f3 == 3'b000) || (f3 == 3'b011) || (f3 == 3'b100) || (f3 == 3'b101);
  assign mergeF6    = (instr[31:26] == 6'b010111);

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !(isVec || useVs1 || useVs2 || useVd || useMask || illegal) && (excCause == '0));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    instrValid |=> outValid);

  // R3
  non_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && !opv) |=> !isVec && !useVd && !useVs2 && !illegal);

  // R4
  scalar_no_vs1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && opv && f3Scalar) |=> !useVs1);

  // R5
  wx_unary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && opv && f3 == 3'b010 && instr[31:26] == 6'b010000) |=> !useVs1 && !useVd && useVs2);

  // R8
  merge_illegal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && opv && mergeF6 && f3MergeEnc && !instr[25] && instr[11:7] == 5'd0)
      |=> illegal && (excCause == CauseW'(2)) && !useVd && !useMask);

  // R9
  move_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && opv && mergeF6 && f3MergeEnc && instr[25]) |=> !illegal && !useVs2 && !useMask);

  // R11
  cause_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !illegal |-> (excCause == '0));

endmodule

bind vdec_top vdec_chk #(.CauseW(CauseW)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .instrValid (instrValid),
  .instr      (instr),
  .outValid   (outValid),
  .isVec      (isVec),
  .useVs1     (useVs1),
  .useVs2     (useVs2),
  .useVd      (useVd),
  .useMask    (useMask),
  .illegal    (illegal),
  .excCause   (excCause)
);

// File: tb/tb_vdec_top.sv
`timescale 1ns/1ps
module tb_vdec_top;

  localparam int CauseW = 5;
  localparam int MaxCycles = 200000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              instrValid = 1'b0;
  logic [31:0]       instr = '0;
  logic              outValid, isVec, useVs1, useVs2, useVd, useMask, illegal;
  logic [CauseW-1:0] excCause;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  vdec_top dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instr(instr),
    .outValid(outValid), .isVec(isVec), .useVs1(useVs1), .useVs2(useVs2),
    .useVd(useVd), .useMask(useMask), .illegal(illegal), .excCause(excCause)
  );

  // packing: {outValid,isVec,useVs1,useVs2,useVd,useMask,illegal,excCause}
  function automatic logic [11:0] refModel(input logic v, input logic [31:0] w);
    int f3, f6, rd;
    bit vm, merge, s1, s2, d;
    f3 = int'(w[14:12]);
    f6 = int'(w[31:26]);
    rd = int'(w[11:7]);
    vm = w[25];
    if (!v) return 12'd0;
    if (w[6:0] != 7'h57 || f3 == 7) return {1'b1, 11'd0};  // R3
    merge = (f6 == 23) && (f3 == 0 || f3 == 3 || f3 == 4 || f3 == 5);
    if (merge && !vm && rd == 0) return {7'b1100001, 5'd2};  // R8
    s1 = (f3 <= 2) && !(f3 == 2 && (f6 == 16 || f6 == 20));  // R4 R5 R6
    s2 = !(merge && vm);                                     // R9 R12
    d  = !(f3 == 2 && f6 == 16);                             // R5 R12
    return {1'b1, 1'b1, s1, s2, d, !vm, 1'b0, 5'd0};         // R7 R11
  endfunction

  function automatic string tagOf(input logic r, input logic v, input logic [31:0] w);
    int f3, f6;
    f3 = int'(w[14:12]);
    f6 = int'(w[31:26]);
    if (!r) return "R1";
    if (!v) return "R2";
    if (w[6:0] != 7'h57 || f3 == 7) return "R3";
    if (f6 == 23 && (f3 == 0 || f3 == 3 || f3 == 4 || f3 == 5)) begin
      if (w[25]) return "R9";
      if (w[11:7] == 5'd0) return "R8";
      return "R10";
    end
    if (f3 == 2 && f6 == 16) return "R5";
    if (f3 == 2 && f6 == 20) return "R6";
    if (!w[25]) return "R7";
    if (f3 >= 3) return "R4";
    return "R12";
  endfunction

  logic [11:0] expQ[$];
  string       tagQ[$];

  always @(posedge clk) begin
    expQ.push_back(rstN ? refModel(instrValid, instr) : 12'd0);
    tagQ.push_back(tagOf(rstN, instrValid, instr));
  end

  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [11:0] e, a;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      a = {outValid, isVec, useVs1, useVs2, useVd, useMask, illegal, excCause};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: outputs {v,vec,s1,s2,d,m,ill,cause} actual %b expected %b", t, a, e);
      end
    end
  end

  function automatic logic [31:0] mk(input int f6, input bit vm, input int vs2,
                                     input int vs1, input int f3, input int vd);
    return {6'(f6), vm, 5'(vs2), 5'(vs1), 3'(f3), 5'(vd), 7'h57};
  endfunction

  task automatic drive(input logic v, input logic [31:0] w);
    @(posedge clk);
    #2;
    instrValid = v;
    instr = w;
  endtask

  int f6List[5] = '{16, 20, 23, 0, 9};

  initial begin
    // R1 reset cycles
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // directed cases
    drive(1, mk(16, 1, 4, 0, 2, 7));   // R5 rs1 sub-opcode 0
    drive(1, mk(16, 1, 4, 17, 2, 0));  // R5 rs1 sub-opcode 17
    drive(1, mk(20, 0, 8, 1, 2, 3));   // R6
    drive(1, mk(23, 0, 20, 0, 3, 0));  // R8 immediate merge onto v0
    drive(1, mk(23, 1, 0, 5, 4, 0));   // R9 move onto v0
    drive(1, mk(23, 0, 20, 2, 5, 6));  // R10 float merge
    drive(1, mk(23, 0, 20, 2, 1, 0));  // R10 OPFVV not policed
    drive(0, mk(23, 0, 20, 0, 0, 0));  // R2 invalid word ignored
    drive(1, 32'h0000_0013);           // R3 not a vector word
    drive(1, mk(0, 0, 1, 2, 7, 0));    // R3 config encoding
    // sweep
    for (int f3 = 0; f3 < 8; f3++)
      for (int k = 0; k < 5; k++)
        for (int vm = 0; vm < 2; vm++)
          for (int vd = 0; vd < 2; vd++)
            drive(1, mk(f6List[k], vm[0], 9, 3, f3, vd * 5));
    // random words, mostly in the vector opcode, with valid gaps
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      w = $urandom;
      if (i % 4 != 0) w[6:0] = 7'h57;
      if (i % 3 == 0) w[31:26] = 6'b010111;
      if (i % 5 == 0) w[11:7] = 5'd0;
      drive((i % 7) != 0, w);
    end
    drive(0, 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * MaxCycles);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule